// File: doc/BRIEF.md
# SPI Flash Command Engine with Addressed Data Buffer

This block runs single SPI flash commands for a host that talks to it through a small byte-wide register port. Software first loads a command byte, a transmit length and a receive length. It then writes the outgoing payload into a buffer window, where each byte sits at its own address. A write to the trigger register starts the transfer, and software polls the same register until the busy bit drops. The incoming bytes are then in the same buffer, placed directly after the payload. The buffer position wraps when the receive data runs past its end.

The engine drives the serial lines in mode 0. The clock idles low, the engine launches data on the falling edge, and it samples data on the rising edge. Chip select stays low for the whole command. A 16-bit clock configuration register holds four 4-bit clock selections. Only the top field, the normal-speed selection, paces command transfers.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, every control register reads zero and so does the whole buffer. Chip select is high and the serial clock is low.
- R2: The enable register is at address 0x00, bit 0, and reads back what was written. While it is 0, a trigger write starts nothing: the trigger bit stays 0 and chip select stays high.
- R3: Writing a byte with bit 7 set to the trigger register (address 0x02) starts a command. Bit 7 of that register reads 1 while the command runs and 0 once it has finished.
- R4: The command byte at address 0x01 is the first byte sent on the serial line, most significant bit first. It is never copied into the buffer.
- R5: Transmit byte i (for i below the transmit count at address 0x03) is taken from buffer address 0x80 + i and sent after the command byte.
- R6: Receive byte i (for i below the receive count at address 0x04) is stored at buffer address 0x80 + ((transmit count + i) mod 71). All other buffer bytes keep their contents.
- R7: A transmit count written above 68 is stored, and reads back, as 68. Values of 68 or less are stored unchanged.
- R8: The clock register reads back in full: low byte at 0x06, high byte at 0x07. Bits 15:12 set the serial clock high time in system cycles: code 4 gives 1, code 0 gives 2, code 1 gives 3, code 2 gives 4, code 3 gives 6. Any other code, whether reserved or 800 kHz, gives the slowest setting of 12.
- R9: Chip select falls exactly once per command and stays low until the last bit has been exchanged. The frame holds exactly 1 + transmit count + receive count bytes.
- R10: While a command runs, bus writes to the enable, command, count and clock registers and to the buffer are ignored.
- R11: The serial clock is low whenever the engine is idle, and the data-out line changes only while the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per byte |
| bus_addr | input | 8 | Register or buffer byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest condition to reach is a receive stream that runs past the end of the buffer and overwrites bytes written earlier in the same command. Wrapping occurs only when the transmit offset plus the receive count goes beyond 71, and that needs a long frame. The stimulus reaches it with directed commands at the fastest clock code. One of these uses a clamped transmit count, so the first receive bytes land in the last three slots before the wrap. Another uses 80 receive bytes after 3 transmit bytes. The flash model gives each frame byte a distinct value, so any misplaced or stale byte appears in the full buffer read-back.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

   // control register addresses on the byte bus
   localparam logic [7:0] REG_ENABLE   = 8'h00;
   localparam logic [7:0] REG_OPCODE   = 8'h01;
   localparam logic [7:0] REG_TRIGGER  = 8'h02;
   localparam logic [7:0] REG_TXCOUNT  = 8'h03;
   localparam logic [7:0] REG_RXCOUNT  = 8'h04;
   localparam logic [7:0] REG_SPEED_LO = 8'h06;
   localparam logic [7:0] REG_SPEED_HI = 8'h07;

   typedef enum logic [1:0] {PH_OPC, PH_TX, PH_RX} phase_e;
   typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT} seq_e;

   // serial clock high (and low) time in system cycles for a clock code
   function automatic logic [7:0] half_period(input logic [3:0] code, input logic [7:0] slowest);
      case (code)
         4'd4:    half_period = 8'd1;
         4'd0:    half_period = 8'd2;
         4'd1:    half_period = 8'd3;
         4'd2:    half_period = 8'd4;
         4'd3:    half_period = 8'd6;
         default: half_period = slowest;
      endcase
   endfunction

endpackage

// File: rtl/spi_cmd_buffer.sv
module spi_cmd_buffer #(
   parameter int BUF_BYTES      = 71,
   parameter int AW             = 7,
   parameter int CLEAR_ON_RESET = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr_a,
   output logic [7:0]    rdata_a,
   input  logic [AW-1:0] raddr_b,
   output logic [7:0]    rdata_b
);

   logic [7:0] mem [BUF_BYTES];

   generate
      if (CLEAR_ON_RESET != 0) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < BUF_BYTES; i++) mem[i] <= '0;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_keep
         logic unused_rst;
         assign unused_rst = rst_n;
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata_a = (int'(raddr_a) < BUF_BYTES) ? mem[raddr_a] : '0;
   assign rdata_b = (int'(raddr_b) < BUF_BYTES) ? mem[raddr_b] : '0;

   p_write_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (int'(waddr) < BUF_BYTES));

endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [7:0]       tx_byte,
   input  logic [DIV_W-1:0] half,
   input  logic             miso,
   output logic             busy,
   output logic             done,
   output logic [7:0]       rx_byte,
   output logic             sclk,
   output logic             mosi
);

   logic [7:0]       sh;
   logic [DIV_W-1:0] div;
   logic [2:0]       bitn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh      <= '0;
         div     <= '0;
         bitn    <= '0;
         busy    <= 1'b0;
         done    <= 1'b0;
         sclk    <= 1'b0;
         rx_byte <= '0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            sh   <= tx_byte;
            busy <= 1'b1;
            div  <= '0;
            bitn <= '0;
            sclk <= 1'b0;
         end else if (busy) begin
            if (div == half - 1'b1) begin
               div <= '0;
               if (!sclk) begin
                  sclk    <= 1'b1;
                  rx_byte <= {rx_byte[6:0], miso};
               end else begin
                  sclk <= 1'b0;
                  if (bitn == 3'd7) begin
                     busy <= 1'b0;
                     done <= 1'b1;
                  end else begin
                     bitn <= bitn + 3'd1;
                     sh   <= {sh[6:0], 1'b0};
                  end
               end
            end else begin
               div <= div + 1'b1;
            end
         end
      end
   end

   assign mosi = sh[7];

   p_mosi_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> $stable(mosi));
   p_sclk_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq import spi_cmd_pkg::*; #(
   parameter int BUF_BYTES = 71,
   parameter int AW        = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [7:0]    opcode,
   input  logic [7:0]    tx_n,
   input  logic [7:0]    rx_n,
   input  logic [7:0]    buf_rdata,
   output logic [AW-1:0] buf_raddr,
   output logic          buf_we,
   output logic [AW-1:0] buf_waddr,
   output logic [7:0]    buf_wdata,
   output logic          sh_start,
   output logic [7:0]    sh_tx,
   input  logic          sh_done,
   input  logic [7:0]    sh_rx,
   input  logic          sh_busy,
   output logic          busy,
   output logic          cs_n
);

   localparam logic [AW-1:0] LAST_SLOT = AW'(BUF_BYTES - 1);

   seq_e          state;
   phase_e        phase;
   logic [7:0]    idx;
   logic [AW-1:0] wptr;
   logic          last_tx, last_rx;

   assign last_tx = ({1'b0, idx} + 9'd1) >= {1'b0, tx_n};
   assign last_rx = ({1'b0, idx} + 9'd1) >= {1'b0, rx_n};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         phase <= PH_OPC;
         idx   <= '0;
         wptr  <= '0;
      end else begin
         case (state)
            SQ_IDLE: if (go) begin
               state <= SQ_ISSUE;
               phase <= PH_OPC;
               idx   <= '0;
               wptr  <= AW'(tx_n);
            end
            SQ_ISSUE: state <= SQ_WAIT;
            SQ_WAIT: if (sh_done) begin
               case (phase)
                  PH_OPC: begin
                     idx <= '0;
                     if (tx_n != 8'd0) begin
                        phase <= PH_TX;
                        state <= SQ_ISSUE;
                     end else if (rx_n != 8'd0) begin
                        phase <= PH_RX;
                        state <= SQ_ISSUE;
                     end else begin
                        state <= SQ_IDLE;
                     end
                  end
                  PH_TX: begin
                     if (!last_tx) begin
                        idx   <= idx + 8'd1;
                        state <= SQ_ISSUE;
                     end else if (rx_n != 8'd0) begin
                        idx   <= '0;
                        phase <= PH_RX;
                        state <= SQ_ISSUE;
                     end else begin
                        state <= SQ_IDLE;
                     end
                  end
                  default: begin
                     wptr <= (wptr == LAST_SLOT) ? '0 : wptr + 1'b1;
                     if (!last_rx) begin
                        idx   <= idx + 8'd1;
                        state <= SQ_ISSUE;
                     end else begin
                        state <= SQ_IDLE;
                     end
                  end
               endcase
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign buf_raddr = idx[AW-1:0];
   assign buf_we    = (state == SQ_WAIT) && sh_done && (phase == PH_RX);
   assign buf_waddr = wptr;
   assign buf_wdata = sh_rx;
   assign sh_start  = (state == SQ_ISSUE);
   assign sh_tx     = (phase == PH_OPC) ? opcode : (phase == PH_TX) ? buf_rdata : 8'h00;
   assign busy      = (state != SQ_IDLE);
   assign cs_n      = (state == SQ_IDLE);

   p_wptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      int'(wptr) < BUF_BYTES);
   p_cs_while_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sh_busy |-> !cs_n);

endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs import spi_cmd_pkg::*; #(
   parameter int BUF_BYTES = 71,
   parameter int BUF_BASE  = 128,
   parameter int AW        = 7,
   parameter int MAX_TX    = 68
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [7:0]    bus_addr,
   input  logic [7:0]    bus_wdata,
   output logic [7:0]    bus_rdata,
   input  logic          busy,
   input  logic [7:0]    buf_rdata,
   output logic [AW-1:0] buf_addr,
   output logic          buf_we,
   output logic [7:0]    buf_wdata,
   output logic          go,
   output logic          enable,
   output logic [7:0]    opcode,
   output logic [7:0]    tx_n,
   output logic [7:0]    rx_n,
   output logic [15:0]   speed
);

   localparam int         WIN_END  = BUF_BASE + BUF_BYTES;
   localparam logic [7:0] TX_LIMIT = 8'(MAX_TX);
   localparam logic [7:0] BASE8    = 8'(BUF_BASE);

   logic in_win, cfg_wr;
   logic [7:0] offs;

   assign in_win   = (int'(bus_addr) >= BUF_BASE) && (int'(bus_addr) < WIN_END);
   assign offs     = bus_addr - BASE8;
   assign buf_addr = offs[AW-1:0];
   assign cfg_wr   = bus_wr && !busy;
   assign buf_we   = cfg_wr && in_win;
   assign buf_wdata = bus_wdata;
   assign go       = cfg_wr && enable && (bus_addr == REG_TRIGGER) && bus_wdata[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable <= 1'b0;
         opcode <= '0;
         tx_n   <= '0;
         rx_n   <= '0;
         speed  <= '0;
      end else if (cfg_wr) begin
         case (bus_addr)
            REG_ENABLE:   enable      <= bus_wdata[0];
            REG_OPCODE:   opcode      <= bus_wdata;
            REG_TXCOUNT:  tx_n        <= (bus_wdata > TX_LIMIT) ? TX_LIMIT : bus_wdata;
            REG_RXCOUNT:  rx_n        <= bus_wdata;
            REG_SPEED_LO: speed[7:0]  <= bus_wdata;
            REG_SPEED_HI: speed[15:8] <= bus_wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (bus_addr)
         REG_ENABLE:   bus_rdata = {7'd0, enable};
         REG_OPCODE:   bus_rdata = opcode;
         REG_TRIGGER:  bus_rdata = {busy, 7'd0};
         REG_TXCOUNT:  bus_rdata = tx_n;
         REG_RXCOUNT:  bus_rdata = rx_n;
         REG_SPEED_LO: bus_rdata = speed[7:0];
         REG_SPEED_HI: bus_rdata = speed[15:8];
         default:      bus_rdata = in_win ? buf_rdata : 8'h00;
      endcase
   end

   p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bus_wr) |=> (opcode == $past(opcode) && tx_n == $past(tx_n) &&
                            rx_n == $past(rx_n) && speed == $past(speed) &&
                            enable == $past(enable)));
   p_txcount_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_n <= TX_LIMIT);

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine import spi_cmd_pkg::*; #(
   parameter int BUF_BYTES      = 71,
   parameter int BUF_BASE       = 128,
   parameter int SLOW_HALF      = 12,
   parameter int CLEAR_ON_RESET = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_wr,
   input  logic [7:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       spi_sclk,
   output logic       spi_cs_n,
   output logic       spi_mosi,
   input  logic       spi_miso
);

   localparam int AW     = $clog2(BUF_BYTES);
   localparam int MAX_TX = BUF_BYTES - 3;

   generate
      if (BUF_BYTES < 4 || BUF_BYTES > 128) begin : g_bad_size
         $error("spi_cmd_engine: BUF_BYTES out of range");
      end
      if (BUF_BASE < 8 || BUF_BASE + BUF_BYTES > 256) begin : g_bad_base
         $error("spi_cmd_engine: buffer window does not fit the byte address space");
      end
      if (SLOW_HALF < 1 || SLOW_HALF > 255) begin : g_bad_slow
         $error("spi_cmd_engine: SLOW_HALF out of range");
      end
   endgenerate

   logic          go, enable, busy;
   logic [7:0]    opcode, tx_n, rx_n;
   logic [15:0]   speed;
   logic [AW-1:0] bus_baddr, eng_raddr, eng_waddr, mem_waddr;
   logic          bus_bwe, eng_we, mem_we;
   logic [7:0]    bus_bwdata, eng_wdata, mem_wdata, bus_brdata, eng_rdata;
   logic          sh_start, sh_done, sh_busy;
   logic [7:0]    sh_tx, sh_rx, half;

   assign half = half_period(speed[15:12], 8'(SLOW_HALF));

   spi_cmd_regs #(
      .BUF_BYTES(BUF_BYTES), .BUF_BASE(BUF_BASE), .AW(AW), .MAX_TX(MAX_TX)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .busy(busy), .buf_rdata(bus_brdata), .buf_addr(bus_baddr), .buf_we(bus_bwe),
      .buf_wdata(bus_bwdata), .go(go), .enable(enable), .opcode(opcode),
      .tx_n(tx_n), .rx_n(rx_n), .speed(speed)
   );

   // bus writes only happen while idle, engine writes only while busy
   assign mem_we    = eng_we | bus_bwe;
   assign mem_waddr = eng_we ? eng_waddr : bus_baddr;
   assign mem_wdata = eng_we ? eng_wdata : bus_bwdata;

   spi_cmd_buffer #(
      .BUF_BYTES(BUF_BYTES), .AW(AW), .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_buf (
      .clk(clk), .rst_n(rst_n),
      .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
      .raddr_a(bus_baddr), .rdata_a(bus_brdata),
      .raddr_b(eng_raddr), .rdata_b(eng_rdata)
   );

   spi_cmd_seq #(
      .BUF_BYTES(BUF_BYTES), .AW(AW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .opcode(opcode), .tx_n(tx_n), .rx_n(rx_n),
      .buf_rdata(eng_rdata), .buf_raddr(eng_raddr), .buf_we(eng_we),
      .buf_waddr(eng_waddr), .buf_wdata(eng_wdata),
      .sh_start(sh_start), .sh_tx(sh_tx), .sh_done(sh_done), .sh_rx(sh_rx),
      .sh_busy(sh_busy), .busy(busy), .cs_n(spi_cs_n)
   );

   spi_cmd_shifter #(
      .DIV_W(8)
   ) u_shift (
      .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(sh_tx), .half(half),
      .miso(spi_miso), .busy(sh_busy), .done(sh_done), .rx_byte(sh_rx),
      .sclk(spi_sclk), .mosi(spi_mosi)
   );

   p_start_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(enable));
   p_no_bus_write_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !bus_bwe);

endmodule

// File: tb/spi_cmd_engine_test.sv
`timescale 1ns/1ps
module spi_cmd_engine_test;

   localparam int BUF = 71;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       spi_sclk, spi_cs_n, spi_mosi, spi_miso;

   int checks = 0;
   int fails = 0;

   logic [7:0] exp_buf [BUF];
   logic [7:0] frm [512];
   int  frm_n = 0;
   int  cs_falls = 0;
   int  mbit = 0;
   int  mbyte = 0;
   logic [7:0] cap = 8'h00;
   realtime t_rise = 0;
   real hi_min = 1.0e9;
   real hi_max = 0.0;

   spi_cmd_engine uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
      .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   always #2.5 clk = ~clk;

   function automatic logic [7:0] resp(input int k);
      return 8'(k * 29 + 195);
   endfunction

   function automatic logic resp_bit(input int k, input int b);
      logic [7:0] v;
      v = resp(k);
      return v[7 - b];
   endfunction

   function automatic int exp_half(input logic [3:0] code);
      case (code)
         4'd4: return 1;
         4'd0: return 2;
         4'd1: return 3;
         4'd2: return 4;
         4'd3: return 6;
         default: return 12;
      endcase
   endfunction

   // flash model: captures bytes on rising edges, answers with a per-byte pattern
   assign spi_miso = spi_cs_n ? 1'b0 : resp_bit(mbyte, mbit);

   always @(posedge spi_sclk or posedge spi_cs_n) begin
      if (spi_cs_n) begin
         mbit = 0;
         mbyte = 0;
      end else begin
         t_rise = $realtime;
         cap = {cap[6:0], spi_mosi};
         mbit = mbit + 1;
         if (mbit == 8) begin
            frm[mbyte] = cap;
            mbyte = mbyte + 1;
            frm_n = mbyte;
            mbit = 0;
         end
      end
   end

   always @(negedge spi_sclk) begin
      if (!spi_cs_n) begin
         if ($realtime - t_rise < hi_min) hi_min = $realtime - t_rise;
         if ($realtime - t_rise > hi_max) hi_max = $realtime - t_rise;
      end
   end

   always @(negedge spi_cs_n) cs_falls = cs_falls + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(posedge clk); #1;
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic check_buffer(input string req);
      logic [7:0] got;
      int errs;
      int first;
      errs = 0;
      first = -1;
      for (int i = 0; i < BUF; i++) begin
         rd(8'(128 + i), got);
         if (got !== exp_buf[i]) begin
            if (first < 0) first = i;
            errs++;
         end
      end
      if (first < 0) chk(1'b1, req, "buffer contents", 0, 0);
      else begin
         rd(8'(128 + first), got);
         chk(1'b0, req, $sformatf("buffer byte %0d", first), got, exp_buf[first]);
      end
   endtask

   task automatic run_cmd(input logic [7:0] op, input int txn_req, input int rxn,
                          input logic [15:0] spd, input bit meddle);
      int txn;
      int polls;
      int errs;
      int w_lo, w_hi, w_exp;
      logic [7:0] v;
      txn = (txn_req > 68) ? 68 : txn_req;
      wr(8'h06, spd[7:0]);
      wr(8'h07, spd[15:8]);
      wr(8'h01, op);
      wr(8'h03, 8'(txn_req));
      wr(8'h04, 8'(rxn));
      for (int i = 0; i < txn; i++) begin
         exp_buf[i] = 8'($urandom);
         wr(8'(128 + i), exp_buf[i]);
      end
      frm_n = 0;
      cs_falls = 0;
      hi_min = 1.0e9;
      hi_max = 0.0;
      wr(8'h02, 8'h80);
      rd(8'h02, v);
      chk(v[7] == 1'b1, "R3", "trigger bit while running", v[7], 1);
      if (meddle) begin
         wr(8'h01, ~op);
         wr(8'h03, 8'd7);
         wr(8'h04, 8'd9);
         wr(8'h07, 8'h40);
         wr(8'h80, ~exp_buf[0]);
         wr(8'h00, 8'h00);
         wr(8'h02, 8'h80);
      end
      polls = 0;
      while (v[7] && polls < 60000) begin
         rd(8'h02, v);
         polls++;
      end
      chk(v[7] == 1'b0, "R3", "trigger bit after completion", v[7], 0);
      chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R11", "idle lines cs_n/sclk",
          {spi_cs_n, spi_sclk}, 2);
      chk(frm_n == 1 + txn + rxn, "R9", "frame byte count", frm_n, 1 + txn + rxn);
      chk(cs_falls == 1, "R9", "chip select falls per command", cs_falls, 1);
      chk(frm[0] == op, "R4", "first frame byte is opcode", frm[0], op);
      errs = 0;
      for (int i = 0; i < txn; i++) if (frm[1 + i] !== exp_buf[i]) errs++;
      chk(errs == 0, "R5", "transmit bytes taken from buffer", errs, 0);
      w_lo = $rtoi(hi_min + 0.5);
      w_hi = $rtoi(hi_max + 0.5);
      w_exp = exp_half(spd[15:12]) * 5;
      chk(w_lo == w_exp && w_hi == w_exp, "R8", "sclk high time ns", w_hi, w_exp);
      for (int i = 0; i < rxn; i++) exp_buf[(txn + i) % BUF] = resp(1 + txn + i);
      check_buffer("R6");
      if (meddle) begin
         rd(8'h01, v); chk(v == op, "R10", "opcode kept", v, op);
         rd(8'h03, v); chk(v == 8'(txn), "R10", "tx count kept", v, txn);
         rd(8'h04, v); chk(v == 8'(rxn), "R10", "rx count kept", v, rxn);
         rd(8'h07, v); chk(v == spd[15:8], "R10", "speed high kept", v, spd[15:8]);
         rd(8'h00, v); chk(v == 8'h01, "R10", "enable kept", v, 1);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] v;
      int errs;
      void'($urandom(32'd20240611));
      for (int i = 0; i < BUF; i++) exp_buf[i] = 8'h00;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      errs = 0;
      for (int a = 0; a < 8; a++) begin
         rd(8'(a), v);
         if (v != 8'h00) errs++;
      end
      chk(errs == 0, "R1", "nonzero control registers", errs, 0);
      chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1", "cs_n/sclk after reset",
          {spi_cs_n, spi_sclk}, 2);
      check_buffer("R1");

      // R2 trigger with engine disabled
      cs_falls = 0;
      wr(8'h02, 8'h80);
      rd(8'h02, v);
      chk(v[7] == 1'b0, "R2", "trigger while disabled", v[7], 0);
      repeat (40) @(posedge clk);
      chk(cs_falls == 0, "R2", "frames while disabled", cs_falls, 0);
      wr(8'h00, 8'h01);
      rd(8'h00, v);
      chk(v == 8'h01, "R2", "enable readback", v, 1);

      // R8 speed register readback
      wr(8'h06, 8'hC3);
      wr(8'h07, 8'hA5);
      rd(8'h06, v); chk(v == 8'hC3, "R8", "speed low byte", v, 8'hC3);
      rd(8'h07, v); chk(v == 8'hA5, "R8", "speed high byte", v, 8'hA5);

      // R7 transmit count clamp
      wr(8'h03, 8'd200); rd(8'h03, v); chk(v == 8'd68, "R7", "tx count 200", v, 68);
      wr(8'h03, 8'd69);  rd(8'h03, v); chk(v == 8'd68, "R7", "tx count 69", v, 68);
      wr(8'h03, 8'd68);  rd(8'h03, v); chk(v == 8'd68, "R7", "tx count 68", v, 68);
      wr(8'h03, 8'd17);  rd(8'h03, v); chk(v == 8'd17, "R7", "tx count 17", v, 17);

      // directed commands
      run_cmd(8'h9F, 0, 3, 16'h4000, 1'b0);    // read-id style, fastest clock
      run_cmd(8'h06, 0, 0, 16'h0123, 1'b0);    // opcode only
      run_cmd(8'h02, 200, 5, 16'h4111, 1'b0);  // clamped tx, rx wraps past end
      run_cmd(8'h0B, 3, 80, 16'h4FFF, 1'b0);   // rx overwrites its own start
      run_cmd(8'h03, 4, 4, 16'h5000, 1'b1);    // reserved code, writes while busy
      run_cmd(8'h05, 2, 2, 16'h7000, 1'b0);    // slowest listed code
      run_cmd(8'hAB, 1, 1, 16'h3000, 1'b0);
      run_cmd(8'hC7, 5, 0, 16'h2000, 1'b0);

      // constrained random commands
      for (int n = 0; n < 10; n++) begin
         run_cmd(8'($urandom), $urandom % 24, $urandom % 24, 16'($urandom), 1'b0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule